// File: doc/BRIEF.md
# Filter Pattern Residual-ISI Sign Decoder

This block sits behind the decision slicers of a serial receiver. Each clock it accepts one recovered data bit together with the error-sign bit that was sampled for that same bit. It keeps a seven-bit history window over the data stream, where D0 is the oldest bit and D6 the newest. It compares that window against one of two fixed bit patterns. The two patterns are identical except at one target position, the cursor whose residual inter-symbol interference is being measured.

When the window equals the pattern currently awaited, the block issues one signed vote. The vote is the product of the sign of the error taken at D4 and the sign of the data bit at the target position. The block then switches to waiting for the other pattern. Because the two patterns are taken strictly in turn and the block never gives up waiting, a downstream integrator that accumulates the votes performs the subtraction of the two conditional error averages using signs alone. That integrator does not drift when the data stream lacks randomness. At the default parameters the pattern pair targets the first post-cursor.

In every cycle without a vote the output is zero, meaning "no update". A vote appears combinationally in the cycle after the seventh bit of a matching window has been accepted, and only while `en` is high.

Top module: `isi_vote_decoder`

## Requirements
- R1: After a synchronous reset the block issues no vote and awaits pattern A first. Pattern A is D0..D6 = 0,0,1,1,0,1,0, stored with bit i holding Di.
- R2: No vote is issued until at least seven bits have been accepted since the last reset.
- R3: Each accepted bit enters at D6 and the older bits move one place toward D0. A vote requires all seven window bits to equal the awaited pattern.
- R4: A vote on pattern A is +1 (`vote` = 2'b01) when the D4 error bit is 1, and -1 (`vote` = 2'b11) when it is 0.
- R5: Pattern B is D0..D6 = 0,0,1,0,0,1,0 and differs from A only at D3. A vote on pattern B is -1 (2'b11) when the D4 error bit is 1, and +1 (2'b01) when it is 0.
- R6: Once a vote has been issued, the block awaits the other pattern from the next cycle on. A window that equals the non-awaited pattern gives no vote.
- R7: There is no timeout. However long the awaited pattern is absent, no vote is issued and the awaited pattern does not change.
- R8: While `en` is low no bit is accepted, the window, fill count and awaited pattern hold, and `vote_valid` is 0.
- R9: When `vote_valid` is 0, `vote` is 2'b00. The code 2'b10 never appears.
- R10: The vote depends only on the error bit that arrived with the data bit now at D4. Error bits of the other window positions have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accept the current bit pair and allow a vote |
| data_in | input | 1 | Recovered data bit (1 = positive symbol) |
| err_in | input | 1 | Error sign for the same bit (1 = above reference) |
| vote_valid | output | 1 | A residual-ISI vote is issued this cycle |
| vote | output | 2 | Two's-complement vote: 01 = +1, 11 = -1, 00 = none |

## Verification
The hardest situation to reach is a long drought of the awaited pattern: uniform random data hits a given seven-bit window only once in about 128 bits. The stimulus therefore flushes the window with zeros and then injects each pattern explicitly. Directed cases include the non-awaited pattern on its own, a 300-bit stretch of zeros, a matching window frozen by a low enable, and patterns whose non-D4 error bits carry the opposite sign. Several thousand random cycles with a random enable then exercise alternation across accidental matches.

// File: rtl/isi_vote_pkg.sv
package isi_vote_pkg;

    // Which of the two patterns the decoder is currently waiting for.
    typedef enum logic {
        EXP_A = 1'b0,
        EXP_B = 1'b1
    } exp_sel_e;

    // Internal vote: a strobe and a negative flag.
    typedef struct packed {
        logic valid;
        logic neg;
    } vote_s;

    // Two's-complement code on the output pins.
    localparam logic [1:0] VOTE_NONE = 2'b00;
    localparam logic [1:0] VOTE_POS  = 2'b01;
    localparam logic [1:0] VOTE_NEG  = 2'b11;

    function automatic logic [1:0] encode_vote(input vote_s v);
        if (!v.valid) begin
            return VOTE_NONE;
        end
        return v.neg ? VOTE_NEG : VOTE_POS;
    endfunction

    function automatic exp_sel_e other_sel(input exp_sel_e s);
        return (s == EXP_A) ? EXP_B : EXP_A;
    endfunction

endpackage

// File: rtl/isi_bit_window.sv
module isi_bit_window #(
    parameter int WIN     = 7,
    parameter int ERR_POS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           data_in,
    input  logic           err_in,
    output logic [WIN-1:0] data_win,
    output logic           err_at_pos,
    output logic           full
);
    // Only error bits from ERR_POS upward are ever needed.
    localparam int ERR_DEPTH = WIN - ERR_POS;
    localparam int CW        = $clog2(WIN + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(WIN);

    logic [WIN-1:0]       win_q;
    logic [ERR_DEPTH-1:0] err_q;
    logic [CW-1:0]        fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            err_q  <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            // Newest bit lands at the top index (D6); D0 falls off.
            win_q <= {data_in, win_q[WIN-1:1]};
            if (ERR_DEPTH > 1) begin
                err_q <= {err_in, err_q[ERR_DEPTH-1:1]};
            end else begin
                err_q <= err_in;
            end
            if (fill_q != FULL_CNT) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    assign data_win   = win_q;
    assign err_at_pos = err_q[0];
    assign full       = (fill_q == FULL_CNT);

endmodule

// File: rtl/isi_pattern_match.sv
module isi_pattern_match
    import isi_vote_pkg::*;
#(
    parameter int             WIN     = 7,
    parameter int             TGT_POS = 3,
    parameter logic [WIN-1:0] PAT_A   = 7'b0101100,
    parameter logic [WIN-1:0] PAT_B   = 7'b0100100
) (
    input  logic [WIN-1:0] data_win,
    input  logic           err_bit,
    input  logic           armed,
    input  exp_sel_e       sel,
    output vote_s          vote
);
    logic [WIN-1:0] target;
    logic           hit;

    always_comb begin
        target = (sel == EXP_A) ? PAT_A : PAT_B;
        hit    = armed && (data_win == target);
        // Product of two signs is negative when exactly one is negative.
        vote.valid = hit;
        vote.neg   = hit && (err_bit ^ data_win[TGT_POS]);
    end

endmodule

// File: rtl/isi_alt_tracker.sv
module isi_alt_tracker
    import isi_vote_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    output exp_sel_e sel
);
    exp_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= EXP_A;
        end else if (advance) begin
            sel_q <= other_sel(sel_q);
        end
    end

    assign sel = sel_q;

endmodule

// File: rtl/isi_vote_decoder.sv
module isi_vote_decoder
    import isi_vote_pkg::*;
#(
    parameter int             WIN     = 7,
    parameter int             ERR_POS = 4,
    parameter int             TGT_POS = 3,
    parameter logic [WIN-1:0] PAT_A   = 7'b0101100,
    parameter logic [WIN-1:0] PAT_B   = 7'b0100100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       data_in,
    input  logic       err_in,
    output logic       vote_valid,
    output logic [1:0] vote
);
    logic [WIN-1:0] data_win;
    logic           err_bit;
    logic           full;
    exp_sel_e       sel;
    vote_s          vote_int;

    isi_bit_window #(
        .WIN     (WIN),
        .ERR_POS (ERR_POS)
    ) u_window (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (en),
        .data_in    (data_in),
        .err_in     (err_in),
        .data_win   (data_win),
        .err_at_pos (err_bit),
        .full       (full)
    );

    isi_pattern_match #(
        .WIN     (WIN),
        .TGT_POS (TGT_POS),
        .PAT_A   (PAT_A),
        .PAT_B   (PAT_B)
    ) u_match (
        .data_win (data_win),
        .err_bit  (err_bit),
        .armed    (full && en),
        .sel      (sel),
        .vote     (vote_int)
    );

    isi_alt_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .advance (vote_int.valid),
        .sel     (sel)
    );

    assign vote_valid = vote_int.valid;
    assign vote       = encode_vote(vote_int);

endmodule

// File: rtl/isi_vote_decoder_chk.sv
module isi_vote_decoder_chk
    import isi_vote_pkg::*;
#(
    parameter int             WIN   = 7,
    parameter logic [WIN-1:0] PAT_A = 7'b0101100,
    parameter logic [WIN-1:0] PAT_B = 7'b0100100
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           vote_valid,
    input logic [1:0]     vote,
    input logic [WIN-1:0] data_win,
    input logic           full,
    input exp_sel_e       sel
);
    // R9: no vote code without the strobe, and no illegal code
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!vote_valid |-> vote == 2'b00) and (vote != 2'b10));

    // R8: disabled cycles issue nothing and freeze the history
    a_r8_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(data_win) && $stable(sel) && $stable(full)));

    a_r8_no_vote_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |-> !vote_valid);

    // R6: a vote flips the awaited pattern, otherwise it stays (R7)
    a_r6_toggle_after_vote: assert property (@(posedge clk) disable iff (rst)
        vote_valid |=> (sel != $past(sel)));

    a_r7_wait_forever: assert property (@(posedge clk) disable iff (rst)
        !vote_valid |=> $stable(sel));

    // R2: votes only once the window has been filled
    a_r2_filled_first: assert property (@(posedge clk) disable iff (rst)
        vote_valid |-> full);

    // R3: a vote implies the window equals the awaited pattern
    a_r3_exact_match: assert property (@(posedge clk) disable iff (rst)
        vote_valid |-> (data_win == ((sel == EXP_A) ? PAT_A : PAT_B)));

endmodule

bind isi_vote_decoder isi_vote_decoder_chk #(
    .WIN   (WIN),
    .PAT_A (PAT_A),
    .PAT_B (PAT_B)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .vote_valid (vote_valid),
    .vote       (vote),
    .data_win   (data_win),
    .full       (full),
    .sel        (sel)
);

// File: tb/test_isi_vote_decoder.sv
module test_isi_vote_decoder;

    localparam logic [6:0] PA = 7'b0101100; // D0..D6 = 0,0,1,1,0,1,0 (bit i = Di)
    localparam logic [6:0] PB = 7'b0100100; // D0..D6 = 0,0,1,0,0,1,0

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       data_in = 1'b0;
    logic       err_in = 1'b0;
    logic       vote_valid;
    logic [1:0] vote;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // bench model state
    logic [6:0] m_win;
    logic [2:0] m_errs;   // errors of bits now at D4, D5, D6 (index 0 = D4)
    int         m_fill;
    logic       m_exp;    // 0 = pattern A awaited
    logic       last_valid;
    logic [1:0] last_vote;

    isi_vote_decoder i_isi_vote_decoder (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .data_in    (data_in),
        .err_in     (err_in),
        .vote_valid (vote_valid),
        .vote       (vote)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [1:0] exp_code(input logic v, input logic e4, input logic d3);
        if (!v) return 2'b00;
        return (e4 == d3) ? 2'b01 : 2'b11;
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual valid/vote=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_win = '0; m_errs = '0; m_fill = 0; m_exp = 1'b0;
    endtask

    task automatic step(input logic e, input logic d, input logic r, input string tag);
        logic       ev;
        logic [1:0] ec;
        @(negedge clk);
        en = e; data_in = d; err_in = r;
        #1;
        ev = e && (m_fill >= 7) && (m_win == (m_exp ? PB : PA));
        ec = exp_code(ev, m_errs[0], m_win[3]);
        last_valid = vote_valid;
        last_vote  = vote;
        check(tag, {vote_valid, vote}, {ev, ec});
        if (e) begin
            m_win  = {d, m_win[6:1]};
            m_errs = {r, m_errs[2:1]};
            if (m_fill < 7) m_fill++;
            if (ev) m_exp = ~m_exp;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    task automatic flush(input string tag);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'($urandom), tag);
    endtask

    // Send a pattern; the error at D4 is e4, other error bits are oth.
    task automatic send_pat(input logic [6:0] p, input logic e4, input logic oth, input string tag);
        for (int i = 0; i < 7; i++) step(1'b1, p[i], (i == 4) ? e4 : oth, tag);
    endtask

    task automatic lit(input string tag, input logic v, input logic [1:0] c);
        check(tag, {last_valid, last_vote}, {v, c});
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, nothing issued while idle (R8 disabled)
        step(1'b0, 1'b1, 1'b1, "R1 idle");
        lit("R1 reset no vote", 1'b0, 2'b00);

        // R2: pattern A arrives as the very first seven bits
        send_pat(PA, 1'b1, 1'b0, "R2 filling");
        step(1'b1, 1'b0, 1'b0, "R4 A err1");
        lit("R4 A with err 1 gives +1", 1'b1, 2'b01);

        // R5: now B awaited, err 1 -> -1
        flush("R3 flush");
        send_pat(PB, 1'b1, 1'b0, "R5 send");
        step(1'b1, 1'b0, 1'b0, "R5 B err1");
        lit("R5 B with err 1 gives -1", 1'b1, 2'b11);

        // R6: A awaited again; pattern B alone must not vote
        flush("R6 flush");
        send_pat(PB, 1'b1, 1'b1, "R6 send");
        step(1'b1, 1'b0, 1'b0, "R6 wrong pattern");
        lit("R6 non-awaited pattern ignored", 1'b0, 2'b00);

        // R10: other error bits opposite to D4 error
        flush("R10 flush");
        send_pat(PA, 1'b1, 1'b0, "R10 send A");
        step(1'b1, 1'b0, 1'b1, "R10 A");
        lit("R10 A uses D4 error only", 1'b1, 2'b01);
        flush("R10 flush");
        send_pat(PB, 1'b0, 1'b1, "R10 send B");
        step(1'b1, 1'b0, 1'b1, "R10 B");
        lit("R10 B err0 gives +1", 1'b1, 2'b01);

        // R8: matching window frozen by low enable
        flush("R8 flush");
        send_pat(PA, 1'b0, 1'b1, "R8 send");
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b1, "R8 disabled");
            lit("R8 no vote while disabled", 1'b0, 2'b00);
        end
        step(1'b1, 1'b0, 1'b0, "R8 resume");
        lit("R8 held window votes on resume, A err0 = -1", 1'b1, 2'b11);

        // R7: long drought, B awaited, then it arrives
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'($urandom), "R7 drought");
        send_pat(PB, 1'b1, 1'b0, "R7 send");
        step(1'b1, 1'b0, 1'b0, "R7 late B");
        lit("R7 still waiting for B after drought", 1'b1, 2'b11);

        // random mix
        for (int i = 0; i < 4000; i++)
            step(($urandom % 8) != 0, 1'($urandom), 1'($urandom), "R3 random");

        // R1: reset mid-stream restores pattern A as awaited, and R2 refill
        do_reset();
        send_pat(PB, 1'b1, 1'b1, "R1 after reset B");
        step(1'b1, 1'b0, 1'b0, "R1 B not awaited");
        lit("R1 B after reset ignored", 1'b0, 2'b00);
        flush("R1 flush");
        send_pat(PA, 1'b0, 1'b0, "R1 send A");
        step(1'b1, 1'b0, 1'b0, "R1 A");
        lit("R1 A awaited after reset", 1'b1, 2'b11);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule